// File: doc/BRIEF.md
# Processor interrupt level arbiter

This block decides which level interrupt, if any, should be presented to the processor core. Three sources are merged into one 16-entry pending vector: external level request lines, the level bits of the software-interrupt register, and two timer-match flags. The flags do not stand for levels of their own. Either one raises level 14.

The merged vector is compared against the processor interrupt level (PIL). The highest pending level strictly above PIL is chosen and turned into a trap type code. That code and a request flag are held in output registers. A pending vectored interrupt ranks above every level. While one is pending, level arbitration is frozen.

A trap handler already running for a higher-numbered external interrupt is not displaced by a lower candidate. The pipeline and trap entry logic consume the outputs. They are outside this block.

Top module: `irq_level_arb`

## Requirements
- R1: A synchronous reset, `rst` high at a rising clock edge, clears `irq_req` to 0 and `irq_tt` to 0.
- R2: The pending vector is `ext_lvl` OR `soft_reg[15:1]`, placed at bit positions 15:1. Bit n of the vector is level n.
- R3: `soft_reg[0]` is the timer match flag and `soft_reg[16]` is the system-timer match flag. When either flag is set, level 14 is pending. Neither flag makes any other level pending.
- R4: Only levels strictly greater than `pil` can be selected. When no pending level exceeds `pil`, the next edge clears `irq_req` and `irq_tt` to 0.
- R5: Among the pending levels above `pil`, the highest-numbered one wins. The trap type is 16 plus the winning level, so it lies in 17..31.
- R6: While `vec_busy` is 1, `irq_req` and `irq_tt` keep their values, whatever the other inputs do.
- R7: The new type is not loaded, and both outputs keep their values, when all three of these hold: `trap_lvl` is nonzero, `cur_tt` lies in the external group 16..31, and `cur_tt` is numerically greater than the new candidate type.
- R8: When `int_en` is 0 and `vec_busy` is 0, the next edge clears `irq_req` and `irq_tt` to 0.
- R9: When a candidate is accepted and differs from `irq_tt`, the next edge loads it into `irq_tt` and sets `irq_req` to 1. The outputs change exactly one clock after the inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_lvl | input | 16 | External level requests; bit n is level n |
| soft_reg | input | 17 | Software-interrupt register: bit 0 is the timer match flag, bit 16 is the system-timer match flag, bits 15:1 are soft levels |
| pil | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap level |
| cur_tt | input | 9 | Trap type of the trap currently being handled |
| vec_busy | input | 1 | A vectored interrupt is pending |
| irq_req | output | 1 | Hardware interrupt request |
| irq_tt | output | 9 | Selected trap type, or 0 when no request is raised |

## Verification
Two registers hold all of this block's state: the request flag and the stored trap type. A fault in either one shows at the ports on the clock edge after the triggering input.

Such a fault looks like one of these:
- a stale type surviving a drop below PIL;
- a request raised or changed while a vectored interrupt is pending;
- a lower candidate replacing a higher-numbered external trap in service.

A fault in the priority scan or in the level-14 fold instead gives a wrong `irq_tt` value one cycle after the pattern is applied. A per-cycle comparison against a behavioural model therefore catches every such fault within one clock.

// File: rtl/irq_level_arb.sv
module irq_level_arb #(
  parameter int NLVL      = 16,
  parameter int TT_W      = 9,
  parameter int TL_W      = 3,
  parameter int EXT_BASE  = 16,
  parameter int TIMER_LVL = 14,
  localparam int LW       = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLVL-1:0] ext_lvl,
  input  logic [NLVL:0]   soft_reg,
  input  logic [LW-1:0]   pil,
  input  logic            int_en,
  input  logic [TL_W-1:0] trap_lvl,
  input  logic [TT_W-1:0] cur_tt,
  input  logic            vec_busy,
  output logic            irq_req,
  output logic [TT_W-1:0] irq_tt
);
  localparam logic [TT_W-1:0] BASE = TT_W'(EXT_BASE);

  logic            tmr;
  logic [NLVL-1:0] pend;
  logic            above;
  logic [LW-1:0]   win;
  logic [TT_W-1:0] cand;
  logic            keep;

  assign tmr   = soft_reg[0] | soft_reg[NLVL];
  assign pend  = ext_lvl | {soft_reg[NLVL-1:1], 1'b0}
               | (tmr ? NLVL'(1) << TIMER_LVL : '0);
  assign above = {1'b0, pend} >= ((NLVL+1)'(2) << pil);

  always_comb begin
    win = '0;
    for (int i = 0; i < NLVL; i++)
      if (pend[i]) win = LW'(i);
  end

  assign cand = BASE | TT_W'(win);
  assign keep = (trap_lvl != '0) && (cur_tt[TT_W-1:LW] == BASE[TT_W-1:LW])
              && (cur_tt > cand);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_tt  <= '0;
    end else if (!vec_busy) begin
      if (!above || !int_en) begin
        irq_req <= 1'b0;
        irq_tt  <= '0;
      end else if (!keep && irq_tt != cand) begin
        irq_req <= 1'b1;
        irq_tt  <= cand;
      end
    end
  end
endmodule

// File: rtl/irq_level_arb_chk.sv
module irq_level_arb_chk #(
  parameter int NLVL = 16,
  parameter int TT_W = 9,
  parameter int EXT_BASE = 16,
  localparam int LW = $clog2(NLVL)
) (
  input logic            clk,
  input logic            rst,
  input logic [NLVL-1:0] ext_lvl,
  input logic [NLVL:0]   soft_reg,
  input logic            int_en,
  input logic            vec_busy,
  input logic            irq_req,
  input logic [TT_W-1:0] irq_tt
);
  localparam logic [TT_W-1:0] BASE = TT_W'(EXT_BASE);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!irq_req && irq_tt == '0));

  p_vec_hold_r6: assert property (@(posedge clk) disable iff (rst)
    vec_busy |=> ($stable(irq_req) && $stable(irq_tt)));

  p_type_range_r5: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_tt[TT_W-1:LW] == BASE[TT_W-1:LW] && irq_tt[LW-1:0] != '0));

  p_disabled_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (!vec_busy && !int_en) |=> (!irq_req && irq_tt == '0));

  p_idle_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (!vec_busy && ext_lvl == '0 && soft_reg == '0) |=> !irq_req);

  p_rise_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> ($past(int_en) && !$past(vec_busy)));
endmodule

bind irq_level_arb irq_level_arb_chk #(.NLVL(NLVL), .TT_W(TT_W), .EXT_BASE(EXT_BASE)) chk_i (.*);

// File: tb/irq_level_arb_tb_top.sv
module irq_level_arb_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ext_lvl = '0;
  logic [16:0] soft_reg = '0;
  logic [3:0]  pil = '0;
  logic        int_en = 1'b0;
  logic [2:0]  trap_lvl = '0;
  logic [8:0]  cur_tt = '0;
  logic        vec_busy = 1'b0;
  logic        irq_req;
  logic [8:0]  irq_tt;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string tag = "R1";

  bit m_req = 0;
  int m_tt = 0;

  always #10 clk = ~clk;

  irq_level_arb dut_i (
    .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .soft_reg(soft_reg), .pil(pil),
    .int_en(int_en), .trap_lvl(trap_lvl), .cur_tt(cur_tt), .vec_busy(vec_busy),
    .irq_req(irq_req), .irq_tt(irq_tt)
  );

  always @(posedge clk) begin
    int p, w, c;
    if (rst) begin
      m_req = 0; m_tt = 0;
    end else if (!vec_busy) begin
      p = int'(ext_lvl) | (int'(soft_reg[15:0]) & 'hFFFE);
      if (soft_reg[0] || soft_reg[16]) p = p | (1 << 14);
      w = -1;
      for (int i = 15; i > int'(pil); i--)
        if (w < 0 && p[i]) w = i;
      if (w < 0 || !int_en) begin
        m_req = 0; m_tt = 0;
      end else begin
        c = 16 + w;
        if (!(trap_lvl != 0 && int'(cur_tt) >= 16 && int'(cur_tt) <= 31
              && int'(cur_tt) > c) && m_tt != c) begin
          m_req = 1; m_tt = c;
        end
      end
    end
  end

  task automatic compare();
    n_cmp++;
    if (irq_req !== m_req || int'(irq_tt) !== m_tt) begin
      n_bad++;
      $display("FAIL %s: req=%0b tt=%0d expected req=%0b tt=%0d",
               tag, irq_req, irq_tt, m_req, m_tt);
    end
  endtask

  task automatic step(input logic [15:0] e, input logic [16:0] s, input logic [3:0] pl,
                      input logic en, input logic [2:0] tl, input logic [8:0] ct,
                      input logic vb);
    ext_lvl = e; soft_reg = s; pil = pl; int_en = en;
    trap_lvl = tl; cur_tt = ct; vec_busy = vb;
    @(negedge clk);
    compare();
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    tag = "R1"; compare();
    rst = 1'b0;
    tag = "R2"; step(16'h0020, '0, 0, 1, 0, 0, 0);
    step('0, 17'h00200, 0, 1, 0, 0, 0);
    step(16'h0004, 17'h00008, 0, 1, 0, 0, 0);
    tag = "R3"; step('0, 17'h00001, 0, 1, 0, 0, 0);
    step('0, '0, 0, 1, 0, 0, 0);
    step('0, 17'h10000, 0, 1, 0, 0, 0);
    step('0, 17'h10001, 15, 1, 0, 0, 0);
    step('0, 17'h00001, 13, 1, 0, 0, 0);
    tag = "R4"; step(16'h0400, '0, 10, 1, 0, 0, 0);
    step(16'h0800, '0, 10, 1, 0, 0, 0);
    step(16'h8000, '0, 15, 1, 0, 0, 0);
    step(16'h03FF, '0, 10, 1, 0, 0, 0);
    tag = "R5"; step(16'hFFFF, '0, 3, 1, 0, 0, 0);
    step(16'h00F0, '0, 3, 1, 0, 0, 0);
    step(16'h0002, '0, 0, 1, 0, 0, 0);
    tag = "R6"; step(16'h8000, '0, 0, 1, 0, 0, 1);
    step('0, '0, 0, 0, 0, 0, 1);
    step(16'h0100, '0, 0, 1, 0, 0, 1);
    step(16'h0100, '0, 0, 1, 0, 0, 0);
    tag = "R7"; step(16'h0020, '0, 0, 1, 1, 9'd30, 0);
    step(16'h0020, '0, 0, 1, 2, 9'h045, 0);
    step(16'h0200, '0, 0, 1, 0, 9'd30, 0);
    step(16'h0020, '0, 0, 1, 1, 9'd26, 0);
    step(16'h0020, '0, 0, 1, 1, 9'd20, 0);
    tag = "R8"; step(16'hFFFF, 17'h1FFFF, 0, 0, 0, 0, 0);
    step(16'hFFFF, 17'h1FFFF, 0, 1, 0, 0, 0);
    tag = "R9";
    for (int k = 0; k < 8; k++) step(16'(1 << (k + 4)), '0, 0, 1, 0, 0, 0);
    tag = "R5";
    for (int k = 0; k < 3000; k++)
      step(16'($urandom), 17'($urandom & (($urandom % 4 == 0) ? 'h1FFFF : 'h10001)),
           4'($urandom), ($urandom % 8) != 0, 3'($urandom % 3), 9'(10 + $urandom % 30),
           ($urandom % 6) == 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule